// File: doc/BRIEF.md
# Dual-Channel Wiper Step Controller

This block keeps two 10-bit wiper codes and changes them when a command arrives. Code 0 is the B-terminal end of the resistor and code 1023 is full scale. A command is a one-cycle strobe with a 4-bit instruction code and a channel-select bit. Each command does one of four things:

- a linear step of one code up or down, with saturation at the ends;
- a left shift (about +6 dB) with special saturation rules;
- a plain right shift (about -6 dB);
- nothing, for codes that have no step meaning.

Each step command acts on either the selected channel or both channels together. A direct-load path writes any value into the selected channel, and it takes priority over a step command in the same cycle.

Control is a two-state handshake machine, shown below. `done` is high exactly while the machine is in ACK.

| From | To | Name | Condition |
|------|----|------|-----------|
| IDLE | ACK | accept | a request is seen |
| ACK | ACK | re-accept | another request arrives back to back |
| ACK | IDLE | release | no request |
| IDLE | IDLE | wait | no request |

A request is `cmd_valid` or `load_en`. The wiper registers are updated on the same clock edge that accepts the request.

Top module: `wiper_step_ctrl`

## Requirements
- R1: While reset is asserted and right after it, both wiper codes are 512 (midscale) and `done` is low.
- R2: Code 14 adds one to the selected channel. Code 15 adds one to both channels. A channel at 1023 stays at 1023.
- R3: Code 6 subtracts one from the selected channel. Code 7 subtracts one from both channels. A channel at 0 stays at 0.
- R4: Code 12 (selected channel) and code 13 (both channels) double the code, with two exceptions. A code of 0 becomes 1. A code of 512 or more becomes 1023. Eleven such steps from 0 reach 1023.
- R5: Code 4 (selected channel) and code 5 (both channels) shift the code right by one bit and fill the top bit with zero. A code of 0 stays 0.
- R6: A single-channel command (codes 4, 6, 12, 14) acts on channel 0 when `cmd_sel`=0 and on channel 1 when `cmd_sel`=1. The other channel keeps its code.
- R7: A both-channel command (codes 5, 7, 13, 15) updates both channels on the same edge, each from its own current value, whatever `cmd_sel` is.
- R8: `load_en` writes `load_data` into the channel chosen by `cmd_sel`. A step command in the same cycle is discarded for both channels.
- R9: Codes 0-3 and 8-11, and cycles with no request, leave both codes unchanged.
- R10: `done` is high for the cycle after each cycle with a request, and low after a cycle without one.
- R11: A change to a wiper code appears on the outputs on the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Step command strobe |
| cmd_code | input | 4 | Instruction code |
| cmd_sel | input | 1 | Channel select (0 or 1) |
| load_en | input | 1 | Direct-load strobe |
| load_data | input | 10 | Value for a direct load |
| wiper0 | output | 10 | Channel 0 wiper code |
| wiper1 | output | 10 | Channel 1 wiper code |
| done | output | 1 | One-cycle acknowledge |

## Verification
A direct load and a step command can arrive in the same cycle. The bench raises `load_en` together with a both-channel increment, and also with a single-channel left shift aimed at the same channel. It then checks that the loaded channel holds exactly `load_data` and that the other channel did not take the step. Separately, saturating left shifts on one channel run alongside idle cycles on the other. A scoreboard follows both channels, together with `done`, on every cycle.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INC,
        OP_DEC,
        OP_SHL,
        OP_SHR
    } step_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } ack_state_e;

    localparam logic [3:0] CODE_SHR_ONE  = 4'd4;
    localparam logic [3:0] CODE_SHR_BOTH = 4'd5;
    localparam logic [3:0] CODE_DEC_ONE  = 4'd6;
    localparam logic [3:0] CODE_DEC_BOTH = 4'd7;
    localparam logic [3:0] CODE_SHL_ONE  = 4'd12;
    localparam logic [3:0] CODE_SHL_BOTH = 4'd13;
    localparam logic [3:0] CODE_INC_ONE  = 4'd14;
    localparam logic [3:0] CODE_INC_BOTH = 4'd15;

endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
    import wiper_step_pkg::*;
(
    input  logic [3:0] code,
    output step_op_e   op,
    output logic       gang
);

    always_comb begin
        op   = OP_NONE;
        gang = 1'b0;
        case (code)
            CODE_INC_ONE:  op = OP_INC;
            CODE_INC_BOTH: begin op = OP_INC; gang = 1'b1; end
            CODE_DEC_ONE:  op = OP_DEC;
            CODE_DEC_BOTH: begin op = OP_DEC; gang = 1'b1; end
            CODE_SHL_ONE:  op = OP_SHL;
            CODE_SHL_BOTH: begin op = OP_SHL; gang = 1'b1; end
            CODE_SHR_ONE:  op = OP_SHR;
            CODE_SHR_BOTH: begin op = OP_SHR; gang = 1'b1; end
            default: begin op = OP_NONE; gang = 1'b0; end
        endcase
    end

endmodule

// File: rtl/wiper_step_alu.sv
module wiper_step_alu
    import wiper_step_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] cur,
    input  step_op_e     op,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
    localparam logic [W-1:0] CODE_MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] CODE_ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] CODE_ZERO = '0;

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_NONE: nxt = cur;
            OP_INC:  nxt = (cur == CODE_MAX) ? CODE_MAX : cur + CODE_ONE;
            OP_DEC:  nxt = (cur == CODE_ZERO) ? CODE_ZERO : cur - CODE_ONE;
            OP_SHL: begin
                if (cur == CODE_ZERO)
                    nxt = CODE_ONE;
                else if (cur >= CODE_MID)
                    nxt = CODE_MAX;
                else
                    nxt = {cur[W-2:0], 1'b0};
            end
            OP_SHR:  nxt = {1'b0, cur[W-1:1]};
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
    import wiper_step_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [3:0]   cmd_code,
    input  logic         cmd_sel,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] wiper0,
    output logic [W-1:0] wiper1,
    output logic         done
);

    localparam int NCH = 2;
    localparam logic [W-1:0] CODE_MID = {1'b1, {(W-1){1'b0}}};

    ack_state_e state_q, state_d;
    step_op_e   op;
    logic       gang;
    logic       req;

    logic [W-1:0] wiper_q [NCH];

    assign req = cmd_valid | load_en;

    wiper_cmd_decode u_dec (
        .code (cmd_code),
        .op   (op),
        .gang (gang)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [W-1:0] alu_nxt;
        logic [W-1:0] wiper_d;
        logic         picked;
        logic         step_hit;

        wiper_step_alu #(.W(W)) u_alu (
            .cur (wiper_q[ch]),
            .op  (op),
            .nxt (alu_nxt)
        );

        always_comb begin
            picked   = (cmd_sel == 1'(ch));
            step_hit = cmd_valid && !load_en && (op != OP_NONE) && (gang || picked);
            if (load_en && picked)
                wiper_d = load_data;
            else if (step_hit)
                wiper_d = alu_nxt;
            else
                wiper_d = wiper_q[ch];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                wiper_q[ch] <= CODE_MID;
            else
                wiper_q[ch] <= wiper_d;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = req ? ST_ACK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done   = (state_q == ST_ACK);
        wiper0 = wiper_q[0];
        wiper1 = wiper_q[1];
    end

endmodule

// File: rtl/wiper_step_chk.sv
module wiper_step_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [3:0]   cmd_code,
    input logic         cmd_sel,
    input logic         load_en,
    input logic [W-1:0] load_data,
    input logic [W-1:0] wiper0,
    input logic [W-1:0] wiper1,
    input logic         done
);

    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
    localparam logic [W-1:0] CODE_MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] CODE_ONE = {{(W-1){1'b0}}, 1'b1};

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_mid: assert (wiper0 == CODE_MID && wiper1 == CODE_MID && !done);
        end
    end

    a_r10_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || load_en) |=> done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid || load_en) |=> !done);

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid || load_en) |=> ($stable(wiper0) && $stable(wiper1)));

    a_r8_load_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !cmd_sel) |=> (wiper0 == $past(load_data) && $stable(wiper1)));

    a_r8_load_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && cmd_sel) |=> (wiper1 == $past(load_data) && $stable(wiper0)));

    a_r2_inc_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !load_en && cmd_code == 4'd14 && !cmd_sel && wiper0 == CODE_MAX)
        |=> wiper0 == CODE_MAX);

    a_r3_dec_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !load_en && cmd_code == 4'd6 && !cmd_sel && wiper0 == '0)
        |=> wiper0 == '0);

    a_r4_shl_zero_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !load_en && cmd_code == 4'd12 && !cmd_sel && wiper0 == '0)
        |=> wiper0 == CODE_ONE);

    a_r4_shl_upper_to_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !load_en && cmd_code == 4'd12 && !cmd_sel && wiper0 >= CODE_MID)
        |=> wiper0 == CODE_MAX);

    a_r6_other_channel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !load_en && !cmd_sel &&
         (cmd_code == 4'd4 || cmd_code == 4'd6 || cmd_code == 4'd12 || cmd_code == 4'd14))
        |=> $stable(wiper1));

endmodule

bind wiper_step_ctrl wiper_step_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_sel   (cmd_sel),
    .load_en   (load_en),
    .load_data (load_data),
    .wiper0    (wiper0),
    .wiper1    (wiper1),
    .done      (done)
);

// File: tb/wiper_step_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_step_ctrl_tb;

    localparam int W = 10;
    localparam int MAXV = 1023;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_code = 4'd0;
    logic         cmd_sel = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] wiper0, wiper1;
    logic         done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m0 = 512;
    int m1 = 512;

    int    q_e0 [$];
    int    q_e1 [$];
    bit    q_ed [$];
    string q_tag [$];

    always #2.5 clk = ~clk;

    wiper_step_ctrl #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_sel(cmd_sel), .load_en(load_en), .load_data(load_data),
        .wiper0(wiper0), .wiper1(wiper1), .done(done)
    );

    function automatic int model_step(int v, int code_kind);
        // 1 inc, 2 dec, 3 shl, 4 shr
        case (code_kind)
            1: return (v == MAXV) ? MAXV : v + 1;
            2: return (v == 0) ? 0 : v - 1;
            3: return (v == 0) ? 1 : ((v >= 512) ? MAXV : v * 2);
            4: return v / 2;
            default: return v;
        endcase
    endfunction

    function automatic int kind_of(int c);
        case (c)
            14, 15: return 1;
            6, 7:   return 2;
            12, 13: return 3;
            4, 5:   return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_gang(int c);
        return (c == 5 || c == 7 || c == 13 || c == 15);
    endfunction

    task automatic drive(bit v, int c, bit s, bit ld, int d, string tag);
        int k;
        @(negedge clk);
        cmd_valid = v;
        cmd_code  = 4'(c);
        cmd_sel   = s;
        load_en   = ld;
        load_data = W'(d);
        k = kind_of(c);
        if (ld) begin
            if (s) m1 = d; else m0 = d;
        end else if (v && k != 0) begin
            if (is_gang(c) || !s) m0 = model_step(m0, k);
            if (is_gang(c) || s)  m1 = model_step(m1, k);
        end
        q_e0.push_back(m0);
        q_e1.push_back(m1);
        q_ed.push_back(v || ld);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compares one scoreboard item per clock, after the edge settles
    always @(posedge clk) begin
        #1;
        if (q_e0.size() > 0) begin
            int e0, e1; bit ed; string tg;
            e0 = q_e0.pop_front();
            e1 = q_e1.pop_front();
            ed = q_ed.pop_front();
            tg = q_tag.pop_front();
            total++;
            if (int'(wiper0) != e0 || int'(wiper1) != e1 || done != ed) begin
                bad++;
                $display("FAIL %s: actual w0=%0d w1=%0d done=%0d expected w0=%0d w1=%0d done=%0d",
                         tg, wiper0, wiper1, done, e0, e1, ed);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (wiper0 != 10'd512 || wiper1 != 10'd512 || done !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: actual w0=%0d w1=%0d done=%0d expected 512 512 0",
                     wiper0, wiper1, done);
        end
        rst_n = 1'b1;

        idle(2, "R10 R9 idle after reset");

        // R8 load, then R4 saturating doubling chain on channel 0
        drive(0, 0, 0, 1, 0, "R8 load ch0 zero");
        for (int i = 0; i < 12; i++) drive(1, 12, 0, 0, 0, "R4 shl ch0 chain, R6 ch1 kept");
        idle(1, "R10 done drops");

        // R5 ganged right shift down to zero and beyond
        for (int i = 0; i < 12; i++) drive(1, 5, 1, 0, 0, "R5 R7 shr both");

        // R4 corner values on channel 1
        drive(0, 0, 1, 1, 511, "R8 load ch1 511");
        drive(1, 12, 1, 0, 0, "R4 shl 511 doubles");
        drive(0, 0, 1, 1, 700, "R8 load ch1 700");
        drive(1, 13, 0, 0, 0, "R4 R7 shl both 700 saturates");

        // R2 increment saturation
        drive(0, 0, 1, 1, 1022, "R8 load ch1 1022");
        drive(1, 14, 1, 0, 0, "R2 R6 inc ch1 to max");
        drive(1, 14, 1, 0, 0, "R2 inc ch1 holds at max");
        drive(0, 0, 0, 1, 100, "R8 load ch0 100");
        drive(1, 15, 0, 0, 0, "R2 R7 inc both");

        // R3 decrement floor
        drive(0, 0, 0, 1, 1, "R8 load ch0 1");
        drive(1, 6, 0, 0, 0, "R3 dec ch0 to zero");
        drive(1, 6, 0, 0, 0, "R3 dec ch0 holds at zero");
        drive(1, 7, 1, 0, 0, "R3 R7 dec both");
        drive(1, 4, 1, 0, 0, "R5 R6 shr ch1 only");

        // R9 codes with no step meaning
        for (int c = 0; c < 12; c++) begin
            if (c < 4 || c > 7) drive(1, c, c[0], 0, 0, "R9 no-op code");
        end

        // R8 priority: load with a step command in the same cycle
        drive(1, 15, 0, 1, 333, "R8 load beats gang inc");
        drive(1, 12, 1, 1, 40, "R8 load beats shl on same channel");
        drive(1, 12, 1, 0, 0, "R11 R4 shl visible next edge");

        idle(3, "R10 final idle");
        wait (q_e0.size() == 0);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule